// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, which pipeline registers of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) keep their contents, which load the next instruction, and which are cleared to an empty slot. It also holds the decode, execute and memory stage registers that these controls act on. The fetch stage outside the block holds its instruction when told to stall. The execute stage supplies one flag: whether the conditional jump now in execute is taken.

Three hazards are resolved together. A load or pop whose destination is read by the instruction behind it costs one cycle. A conditional jump that was predicted taken but turns out not taken cancels the two instructions fetched from its target. A return holds fetch until it reaches write-back. When two of these coincide, fixed priorities apply. All controls are combinational from the current stage contents and take effect at the next rising clock edge.

Top module: `hzd_ctl_top`

## Requirements
- R1: During and right after reset, the decode, execute and memory registers hold an empty slot, and stall_f, stall_d, bubble_d, bubble_e and pipe_err are all 0.
- R2: When the execute op is load (0x5) or pop (0xB) and its load destination equals the decode ra or rb, stall_f, stall_d and bubble_e are 1 in that cycle. At the next edge decode keeps its contents and execute becomes an empty slot. This costs one cycle.
- R3: When the execute op is conditional jump (0x7) and ex_taken is 0, bubble_d and bubble_e are 1. At the next edge both registers become empty slots, so two fetched instructions are cancelled. With ex_taken at 1 the pipeline advances normally.
- R4: While a return (0x9) sits in decode, execute or memory, stall_f and bubble_d are 1. A return that arrives alone is followed by exactly three empty slots.
- R5: If a load/use hazard and a pending return occur in the same cycle, bubble_d stays 0 and the return stays in decode for one extra cycle. It then proceeds as in R4.
- R6: If a mispredicted jump is in execute while a return is in decode, the misprediction action applies: bubble_d=1, bubble_e=1, stall_d=0. stall_f is also 1.
- R7: An empty slot has op nop (0x1), ra, rb and load destination all 0xF, and tag 0.
- R8: pipe_err is 1 exactly when the decode register is asked to stall and to bubble at once. In that case the stall wins. The control priorities keep it 0 for every instruction sequence.
- R9: The memory register loads the execute register's contents at every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fet_op | input | 4 | Op code of the instruction offered by fetch |
| fet_ra | input | 4 | First source register ID of the fetched instruction |
| fet_rb | input | 4 | Second source register ID of the fetched instruction |
| fet_dm | input | 4 | Load destination register ID of the fetched instruction |
| fet_tag | input | 8 | Identifier carried with the fetched instruction |
| ex_taken | input | 1 | Taken flag of the jump now in execute |
| stall_f | output | 1 | Fetch must hold its instruction at the next edge |
| stall_d | output | 1 | Decode register holds at the next edge |
| bubble_d | output | 1 | Decode register becomes an empty slot at the next edge |
| bubble_e | output | 1 | Execute register becomes an empty slot at the next edge |
| pipe_err | output | 1 | Stall and bubble requested together on decode |
| dec_op | output | 4 | Op code in the decode register |
| dec_ra | output | 4 | First source ID in the decode register |
| dec_rb | output | 4 | Second source ID in the decode register |
| dec_tag | output | 8 | Tag in the decode register |
| exe_op | output | 4 | Op code in the execute register |
| exe_dm | output | 4 | Load destination in the execute register |
| exe_tag | output | 8 | Tag in the execute register |
| mem_op | output | 4 | Op code in the memory register |
| mem_tag | output | 8 | Tag in the memory register |

## Verification
A wrong stage content shows up within one edge as a wrong tag on the decode, execute or memory outputs. Each tag then moves one stage per cycle, so a lost, duplicated or wrongly kept instruction is visible at the memory outputs at most two cycles later. A wrong priority between the hazards shows in the control outputs in the very cycle the hazards coincide. It also changes how many empty slots follow a return, which the per-cycle tag sequence exposes.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int OP_W  = 4;
  localparam int REG_W = 4;
  localparam int TAG_W = 8;

  localparam logic [OP_W-1:0]  OP_NOP  = 4'h1;
  localparam logic [OP_W-1:0]  OP_LOAD = 4'h5;
  localparam logic [OP_W-1:0]  OP_ALU  = 4'h6;
  localparam logic [OP_W-1:0]  OP_JCC  = 4'h7;
  localparam logic [OP_W-1:0]  OP_RET  = 4'h9;
  localparam logic [OP_W-1:0]  OP_POP  = 4'hB;
  localparam logic [REG_W-1:0] NO_REG  = {REG_W{1'b1}};

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [REG_W-1:0] dm;
    logic [TAG_W-1:0] tag;
  } slot_t;

  localparam slot_t EMPTY_SLOT = '{op: OP_NOP, ra: NO_REG, rb: NO_REG,
                                   dm: NO_REG, tag: '0};

  // op writes a register from memory
  function automatic logic f_mem_writer(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_POP);
  endfunction

  // destination read by either source of the younger instruction
  function automatic logic f_reads(input logic [REG_W-1:0] dst,
                                   input logic [REG_W-1:0] a,
                                   input logic [REG_W-1:0] b);
    return (dst == a) || (dst == b);
  endfunction
endpackage

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
(
  input  slot_t dec_q,
  input  slot_t exe_q,
  input  slot_t mem_q,
  input  logic  ex_taken,
  output logic  lu_haz,
  output logic  mispred,
  output logic  ret_busy
);
  always_comb begin
    lu_haz   = f_mem_writer(exe_q.op) && f_reads(exe_q.dm, dec_q.ra, dec_q.rb);
    mispred  = (exe_q.op == OP_JCC) && !ex_taken;
    ret_busy = (dec_q.op == OP_RET) || (exe_q.op == OP_RET) ||
               (mem_q.op == OP_RET);
  end
endmodule

// File: rtl/hzd_stage_reg.sv
module hzd_stage_reg
  import hzd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  flush,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= EMPTY_SLOT;
    else if (hold)  q <= q;
    else if (flush) q <= EMPTY_SLOT;
    else            q <= d;
  end
endmodule

// File: rtl/hzd_ctl_top.sv
module hzd_ctl_top
  import hzd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  fet_op,
  input  logic [REG_W-1:0] fet_ra,
  input  logic [REG_W-1:0] fet_rb,
  input  logic [REG_W-1:0] fet_dm,
  input  logic [TAG_W-1:0] fet_tag,
  input  logic             ex_taken,
  output logic             stall_f,
  output logic             stall_d,
  output logic             bubble_d,
  output logic             bubble_e,
  output logic             pipe_err,
  output logic [OP_W-1:0]  dec_op,
  output logic [REG_W-1:0] dec_ra,
  output logic [REG_W-1:0] dec_rb,
  output logic [TAG_W-1:0] dec_tag,
  output logic [OP_W-1:0]  exe_op,
  output logic [REG_W-1:0] exe_dm,
  output logic [TAG_W-1:0] exe_tag,
  output logic [OP_W-1:0]  mem_op,
  output logic [TAG_W-1:0] mem_tag
);
  slot_t fet_w, dec_q, exe_q, mem_q;
  logic  lu_w, mis_w, ret_w;

  assign fet_w = '{op: fet_op, ra: fet_ra, rb: fet_rb, dm: fet_dm, tag: fet_tag};

  hzd_detect i_detect (
    .dec_q(dec_q), .exe_q(exe_q), .mem_q(mem_q), .ex_taken(ex_taken),
    .lu_haz(lu_w), .mispred(mis_w), .ret_busy(ret_w)
  );

  // priorities: load/use beats the return's decode bubble
  always_comb begin
    stall_f  = lu_w || ret_w;
    stall_d  = lu_w;
    bubble_d = mis_w || (ret_w && !lu_w);
    bubble_e = mis_w || lu_w;
    pipe_err = stall_d && bubble_d;
  end

  hzd_stage_reg i_dec (.clk(clk), .rst_n(rst_n), .hold(stall_d), .flush(bubble_d),
                       .d(fet_w), .q(dec_q));
  hzd_stage_reg i_exe (.clk(clk), .rst_n(rst_n), .hold(1'b0), .flush(bubble_e),
                       .d(dec_q), .q(exe_q));
  hzd_stage_reg i_mem (.clk(clk), .rst_n(rst_n), .hold(1'b0), .flush(1'b0),
                       .d(exe_q), .q(mem_q));

  assign dec_op  = dec_q.op;
  assign dec_ra  = dec_q.ra;
  assign dec_rb  = dec_q.rb;
  assign dec_tag = dec_q.tag;
  assign exe_op  = exe_q.op;
  assign exe_dm  = exe_q.dm;
  assign exe_tag = exe_q.tag;
  assign mem_op  = mem_q.op;
  assign mem_tag = mem_q.tag;
endmodule

// File: rtl/hzd_chk.sv
module hzd_chk
  import hzd_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  lu_w,
  input logic  mis_w,
  input logic  ret_w,
  input logic  bubble_d,
  input logic  pipe_err,
  input slot_t dec_q,
  input slot_t exe_q,
  input slot_t mem_q
);
  p_lu_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lu_w |=> (dec_q == $past(dec_q)) && (exe_q == EMPTY_SLOT));

  p_mis_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mis_w |=> (dec_q == EMPTY_SLOT) && (exe_q == EMPTY_SLOT));

  p_ret_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_w && !lu_w) |=> (dec_q == EMPTY_SLOT));

  p_ret_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_w && lu_w) |=> (dec_q.op == OP_RET) && (dec_q == $past(dec_q)));

  p_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_err);

  p_combo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_w && ret_w) |-> bubble_d);

  p_mem_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mem_q == $past(exe_q)));
endmodule

bind hzd_ctl_top hzd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lu_w(lu_w), .mis_w(mis_w), .ret_w(ret_w),
  .bubble_d(bubble_d), .pipe_err(pipe_err),
  .dec_q(dec_q), .exe_q(exe_q), .mem_q(mem_q)
);

// File: tb/test_hzd_ctl_top.sv
`timescale 1ns/1ps
module test_hzd_ctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fet_op = 4'h1, fet_ra = 4'hF, fet_rb = 4'hF, fet_dm = 4'hF;
  logic [7:0] fet_tag = 8'h00;
  logic       ex_taken = 1'b0;
  logic       stall_f, stall_d, bubble_d, bubble_e, pipe_err;
  logic [3:0] dec_op, dec_ra, dec_rb, exe_op, exe_dm, mem_op;
  logic [7:0] dec_tag, exe_tag, mem_tag;

  always #4 clk = ~clk;  // 125 MHz

  hzd_ctl_top i_hzd_ctl_top (.*);

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // program in fetch order
  logic [3:0] p_op [8], p_ra [8], p_rb [8], p_dm [8];
  logic [7:0] p_tag [8];
  int         plen;
  // per-edge snapshots: index k = after edge k
  logic [7:0] s_d [16], s_e [16], s_m [16];
  logic [4:0] s_c [16];  // {pipe_err, stall_f, stall_d, bubble_d, bubble_e}

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<20000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr_prog();
    plen = 0;
  endtask

  task automatic add(input logic [3:0] op, input logic [3:0] ra, input logic [3:0] rb,
                     input logic [3:0] dm, input logic [7:0] tag);
    p_op[plen] = op; p_ra[plen] = ra; p_rb[plen] = rb; p_dm[plen] = dm; p_tag[plen] = tag;
    plen++;
  endtask

  task automatic run(input int n);
    int idx = 0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
    s_d[0] = dec_tag; s_e[0] = exe_tag; s_m[0] = mem_tag;
    for (int k = 0; k < n; k++) begin
      if (idx < plen) begin
        fet_op = p_op[idx]; fet_ra = p_ra[idx]; fet_rb = p_rb[idx];
        fet_dm = p_dm[idx]; fet_tag = p_tag[idx];
      end else begin
        fet_op = 4'h1; fet_ra = 4'hF; fet_rb = 4'hF; fet_dm = 4'hF; fet_tag = 8'hF0;
      end
      #1;
      s_c[k] = {pipe_err, stall_f, stall_d, bubble_d, bubble_e};
      @(posedge clk);
      @(negedge clk);
      if (!s_c[k][3]) idx++;
      s_d[k+1] = dec_tag; s_e[k+1] = exe_tag; s_m[k+1] = mem_tag;
    end
  endtask

  task automatic snap(input string req, input int k, input logic [7:0] d,
                      input logic [7:0] e, input logic [7:0] m);
    chk({req, " dec"}, s_d[k], d);
    chk({req, " exe"}, s_e[k], e);
    chk({req, " mem"}, s_m[k], m);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 dec op", dec_op, 4'h1);
    chk("R1 exe op", exe_op, 4'h1);
    chk("R1 mem op", mem_op, 4'h1);
    chk("R1 ids", {dec_ra, dec_rb, exe_dm}, 12'hFFF);
    chk("R1 ctl", {pipe_err, stall_f, stall_d, bubble_d, bubble_e}, 5'b0);
  endtask

  task automatic t_load_use();
    ex_taken = 1'b0;
    clr_prog();
    add(4'h5, 4'hF, 4'hF, 4'h3, 8'd1);
    add(4'h6, 4'hF, 4'h3, 4'hF, 8'd2);
    add(4'h6, 4'h2, 4'h2, 4'hF, 8'd3);
    add(4'h6, 4'h2, 4'h2, 4'hF, 8'd4);
    run(6);
    chk("R1 ctl after reset", s_c[0], 5'b0);
    chk("R2 ctl", s_c[2], 5'b01101);
    snap("R2 e2", 2, 8'd2, 8'd1, 8'd0);
    snap("R2 e3 hold", 3, 8'd2, 8'd0, 8'd1);
    snap("R2 e4", 4, 8'd3, 8'd2, 8'd0);
    snap("R9 e5", 5, 8'd4, 8'd3, 8'd2);
  endtask

  task automatic t_mispredict(input logic taken);
    ex_taken = taken;
    clr_prog();
    add(4'h7, 4'hF, 4'hF, 4'hF, 8'd1);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd2);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd3);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd4);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd5);
    run(6);
    if (!taken) begin
      chk("R3 ctl", s_c[2], 5'b00011);
      snap("R3 e3 cancel", 3, 8'd0, 8'd0, 8'd1);
      snap("R3 e4", 4, 8'd4, 8'd0, 8'd0);
      snap("R3 e5", 5, 8'd5, 8'd4, 8'd0);
    end else begin
      chk("R3 taken ctl", s_c[2], 5'b00000);
      snap("R3 taken e3", 3, 8'd3, 8'd2, 8'd1);
    end
    ex_taken = 1'b0;
  endtask

  task automatic t_bubble_fields();
    // right after the mispredict cancel: decode and execute are empty slots
    ex_taken = 1'b0;
    clr_prog();
    add(4'h7, 4'hF, 4'hF, 4'hF, 8'd1);
    add(4'h5, 4'h1, 4'h2, 4'h3, 8'd2);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd3);
    run(3);
    chk("R7 dec op", dec_op, 4'h1);
    chk("R7 ids", {dec_ra, dec_rb, exe_dm}, 12'hFFF);
    chk("R7 tags", {dec_tag, exe_tag}, 16'h0000);
  endtask

  task automatic t_return();
    clr_prog();
    add(4'h9, 4'h4, 4'h4, 4'hF, 8'd1);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd2);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd3);
    run(7);
    chk("R4 ctl d", s_c[1], 5'b01010);
    chk("R4 ctl m", s_c[3], 5'b01010);
    chk("R4 ctl free", s_c[4], 5'b00000);
    snap("R4 e2", 2, 8'd0, 8'd1, 8'd0);
    snap("R4 e3", 3, 8'd0, 8'd0, 8'd1);
    snap("R4 e4", 4, 8'd0, 8'd0, 8'd0);
    snap("R4 e5", 5, 8'd2, 8'd0, 8'd0);
    snap("R4 e6", 6, 8'd3, 8'd2, 8'd0);
  endtask

  task automatic t_combo_a();
    ex_taken = 1'b0;
    clr_prog();
    add(4'h7, 4'hF, 4'hF, 4'hF, 8'd1);
    add(4'h9, 4'h4, 4'h4, 4'hF, 8'd2);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd3);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd4);
    run(6);
    chk("R6 ctl", s_c[2], 5'b01011);
    snap("R6 e2", 2, 8'd2, 8'd1, 8'd0);
    snap("R6 e3", 3, 8'd0, 8'd0, 8'd1);
    snap("R6 e4", 4, 8'd3, 8'd0, 8'd0);
    snap("R6 e5", 5, 8'd4, 8'd3, 8'd0);
  endtask

  task automatic t_combo_b();
    clr_prog();
    add(4'hB, 4'h4, 4'hF, 4'h4, 8'd1);
    add(4'h9, 4'h4, 4'h4, 4'hF, 8'd2);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd3);
    add(4'h6, 4'h1, 4'h2, 4'hF, 8'd4);
    run(9);
    chk("R5 ctl", s_c[2], 5'b01101);
    chk("R8 no err", s_c[2][4], 1'b0);
    chk("R5 ctl next", s_c[3], 5'b01010);
    snap("R5 e3 ret kept", 3, 8'd2, 8'd0, 8'd1);
    snap("R5 e4", 4, 8'd0, 8'd2, 8'd0);
    snap("R5 e5", 5, 8'd0, 8'd0, 8'd2);
    snap("R5 e6", 6, 8'd0, 8'd0, 8'd0);
    snap("R5 e7", 7, 8'd3, 8'd0, 8'd0);
    snap("R5 e8", 8, 8'd4, 8'd3, 8'd0);
  endtask

  initial begin
    t_reset();
    t_load_use();
    t_mispredict(1'b0);
    t_mispredict(1'b1);
    t_bubble_fields();
    t_return();
    t_combo_a();
    t_combo_b();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule